// File: doc/BRIEF.md
# Memory-Mapped 64-bit Compare Timer

This peripheral keeps a free-running 64-bit up-counter that is paced by an 8-bit clock divider. The counter is compared against a 64-bit target. When comparison is switched on and the counter has reached or passed the target, a sticky event flag is set. That flag, gated by an interrupt enable, drives a single interrupt line. An optional step value can be added to the target on every event, so the block can produce a periodic tick without software reloading the target.

Software reaches every register as a 32-bit word through a plain register bus: a word address, a write strobe, write data and combinational read data. The counter and the target are each split across two words. The counter halves are read live, so a carry between two reads can be seen. Software guards against this by reading the upper half twice. To move the target, software first turns comparison off, then writes both halves, then turns comparison on again. This keeps a half-written target from raising a false event.

Top module: `cmp_timer`

## Requirements
- R1: After reset every register reads zero, the counter does not advance and `irq_o` is low.
- R2: With the run bit (control bit 0) set, the counter rises by one after every (divider + 1) clocks, where the divider is control bits [15:8]. With run clear, the counter holds its value.
- R3: The low half of the counter (byte offset 0x00) and the high half (0x04) are writable, and a write wins over an increment in the same cycle. Each read returns the live value of that half, so a carry between a low read and a high read shows up in the two results.
- R4: With compare enable (control bit 1) set, the event flag (status word at 0x0C, bit 0) is set whenever the counter is greater than or equal to the target. The target's low half is at 0x10 and its high half at 0x14.
- R5: The event flag stays set until software writes a 1 to status bit 0. Writing 0 there has no effect. A new event in the same cycle as a clear leaves the flag set.
- R6: Without auto-step, one event is raised per entry into the greater-or-equal condition. Clearing the flag while the condition still holds does not set it again. It is set again once the condition has dropped and then returned.
- R7: With auto-step (control bit 3) set, each event adds the 32-bit step word at 0x18 to the target. The result is one event per step.
- R8: `irq_o` is high exactly when the event flag is set and interrupt enable (control bit 2) is set.
- R9: With compare enable clear, no event is raised, including when either target half is rewritten to a value at or below the counter.
- R10: The control word reads back only bits [3:0] and [15:8], with all other bits zero. The unused word at 0x1C reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 5 | Byte address of the 32-bit word; bits [1:0] are ignored |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| irq_o | output | 1 | Interrupt request, level high |

## Verification
A divider phase that is off by one shows up as counter reads drifting from the bench model within two divider periods. A wrong carry shows up in the next read of the high half. A target that advances wrongly, or a repeat guard that is stuck, first appears as a flag set one event too early or too late. This is seen in the status word and on `irq_o` on the clock after the counter crosses the target. The bench models the register file cycle by cycle and compares every read and the interrupt line on every clock, so such a fault is reported within a few cycles of its cause.

// File: rtl/cmp_timer_pkg.sv
// Shared constants of the compare timer: word indices of the register map
// and bit positions inside the control word. Software decodes these, so the
// values are fixed.
package cmp_timer_pkg;
    localparam int W_CNT_LO  = 0;
    localparam int W_CNT_HI  = 1;
    localparam int W_CTRL    = 2;
    localparam int W_STAT    = 3;
    localparam int W_CMP_LO  = 4;
    localparam int W_CMP_HI  = 5;
    localparam int W_STEP    = 6;

    localparam int B_RUN     = 0;
    localparam int B_CMP_EN  = 1;
    localparam int B_IRQ_EN  = 2;
    localparam int B_AUTO    = 3;
    localparam int B_DIV_LSB = 8;
    localparam int B_FLAG    = 0;

    typedef struct packed {
        logic       auto_en;
        logic       irq_en;
        logic       cmp_en;
        logic       run;
    } ctrl_bits_t;
endpackage

// File: rtl/cmp_timer_prescale.sv
// Clock divider for the compare timer.
// Emits a one-cycle tick after every (div_i + 1) clocks while run_i is high.
// Assumes div_i may change at any time; a phase already at or past the new
// value ticks at once, so a shrinking divider never waits for a wrap.
module cmp_timer_prescale #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] phase_q;

    assign tick_o = run_i && (phase_q >= div_i);

    // Phase counter: restarts on every tick and sits at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run_i || tick_o) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + DIV_W'(1);
        end
    end

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !tick_o); // R2
    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (phase_q == '0)); // R2
endmodule

// File: rtl/cmp_timer_count.sv
// 64-bit up-counter built from bus-width words.
// Each word may be loaded by software; a load wins over the increment for
// that word, while other words still take their share of the carry.
// Assumes CNT_W is a whole multiple of WORD_W.
module cmp_timer_count #(
    parameter int CNT_W  = 64,
    parameter int WORD_W = 32,
    localparam int NWORDS = CNT_W / WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [NWORDS-1:0] wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  cnt_o
);
    logic [WORD_W-1:0] word_q [NWORDS];
    logic [CNT_W-1:0]  inc;

    assign inc = cnt_o + CNT_W'(1);

    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        assign cnt_o[i*WORD_W +: WORD_W] = word_q[i];

        // One counter word: software load first, then the increment.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[i] <= '0;
            end else if (wr_i[i]) begin
                word_q[i] <= wdata_i;
            end else if (tick_i) begin
                word_q[i] <= inc[i*WORD_W +: WORD_W];
            end
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !(|wr_i)) |=> (cnt_o == $past(cnt_o) + CNT_W'(1))); // R2
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !(|wr_i)) |=> $stable(cnt_o)); // R2
endmodule

// File: rtl/cmp_timer_match.sv
// Target register, greater-or-equal comparator, auto-step and event flag.
// An event fires when comparison is on, the counter is at or past the target,
// and no earlier event already covers this crossing. With auto-step, each
// event moves the target on and re-arms, giving one event per step.
// Assumes the step is no wider than one bus word.
module cmp_timer_match #(
    parameter int CNT_W  = 64,
    parameter int WORD_W = 32,
    localparam int NWORDS = CNT_W / WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              cmp_en_i,
    input  logic              auto_en_i,
    input  logic [WORD_W-1:0] step_i,
    input  logic [NWORDS-1:0] cmp_wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              clr_i,
    output logic [CNT_W-1:0]  cmp_o,
    output logic              flag_o
);
    logic [WORD_W-1:0] cmp_q [NWORDS];
    logic [CNT_W-1:0]  step_ext;
    logic [CNT_W-1:0]  cmp_next;
    logic              at_or_past;
    logic              fire;
    logic              advance;
    logic              held_q;
    logic              flag_q;

    assign step_ext   = CNT_W'(step_i);
    assign cmp_next   = cmp_o + step_ext;
    assign at_or_past = cmp_en_i && (cnt_i >= cmp_o);
    assign fire       = at_or_past && !held_q;
    assign advance    = fire && auto_en_i;
    assign flag_o     = flag_q;

    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        assign cmp_o[i*WORD_W +: WORD_W] = cmp_q[i];

        // One target word: software write first, then the auto-step.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_q[i] <= '0;
            end else if (cmp_wr_i[i]) begin
                cmp_q[i] <= wdata_i;
            end else if (advance) begin
                cmp_q[i] <= cmp_next[i*WORD_W +: WORD_W];
            end
        end
    end

    // Repeat guard: blocks re-firing until the condition drops or a step re-arms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
        end else begin
            held_q <= at_or_past && !advance;
        end
    end

    // Sticky event flag: an event in the same cycle beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (fire) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    AST_FLAG_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> flag_o); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o); // R5
    AST_NO_EVENT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en_i |-> !fire); // R9
    AST_AUTO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !(|cmp_wr_i)) |=> (cmp_o == $past(cmp_o) + $past(step_ext))); // R7
    AST_SINGLE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !auto_en_i) |=> !fire); // R6
endmodule

// File: rtl/cmp_timer.sv
// Top of the compare timer: register decode, control and step registers,
// and the read multiplexer.
// Assumes one word access per cycle, read data taken combinationally, and a
// counter exactly two bus words wide so the map below fits.
module cmp_timer #(
    parameter int BUS_W  = 32,
    parameter int CNT_W  = 64,
    parameter int DIV_W  = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq_o
);
    import cmp_timer_pkg::*;

    localparam int IDX_W  = ADDR_W - 2;
    localparam int NWORDS = CNT_W / BUS_W;

    logic [IDX_W-1:0]  idx;
    ctrl_bits_t        ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic [BUS_W-1:0]  step_q;
    logic [NWORDS-1:0] cnt_wr;
    logic [NWORDS-1:0] cmp_wr;
    logic              ctrl_wr;
    logic              step_wr;
    logic              clr;
    logic              tick;
    logic              flag;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cmp;
    logic [BUS_W-1:0]  ctrl_rd;
    logic [BUS_W-1:0]  stat_rd;

    assign idx = bus_addr[ADDR_W-1:2];

    for (genvar i = 0; i < NWORDS; i++) begin : g_dec
        assign cnt_wr[i] = bus_wr && (idx == IDX_W'(W_CNT_LO + i));
        assign cmp_wr[i] = bus_wr && (idx == IDX_W'(W_CMP_LO + i));
    end

    assign ctrl_wr = bus_wr && (idx == IDX_W'(W_CTRL));
    assign step_wr = bus_wr && (idx == IDX_W'(W_STEP));
    assign clr     = bus_wr && (idx == IDX_W'(W_STAT)) && bus_wdata[B_FLAG];

    // Control register: mode bits and divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            div_q  <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.run     <= bus_wdata[B_RUN];
            ctrl_q.cmp_en  <= bus_wdata[B_CMP_EN];
            ctrl_q.irq_en  <= bus_wdata[B_IRQ_EN];
            ctrl_q.auto_en <= bus_wdata[B_AUTO];
            div_q          <= bus_wdata[B_DIV_LSB +: DIV_W];
        end
    end

    // Auto-step register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (step_wr) begin
            step_q <= bus_wdata;
        end
    end

    cmp_timer_prescale #(.DIV_W(DIV_W)) u_prescale (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (ctrl_q.run),
        .div_i  (div_q),
        .tick_o (tick)
    );

    cmp_timer_count #(.CNT_W(CNT_W), .WORD_W(BUS_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .wr_i    (cnt_wr),
        .wdata_i (bus_wdata),
        .cnt_o   (cnt)
    );

    cmp_timer_match #(.CNT_W(CNT_W), .WORD_W(BUS_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_i     (cnt),
        .cmp_en_i  (ctrl_q.cmp_en),
        .auto_en_i (ctrl_q.auto_en),
        .step_i    (step_q),
        .cmp_wr_i  (cmp_wr),
        .wdata_i   (bus_wdata),
        .clr_i     (clr),
        .cmp_o     (cmp),
        .flag_o    (flag)
    );

    assign irq_o = flag && ctrl_q.irq_en;

    // Readback words for control and status, unused bits zero.
    always_comb begin
        ctrl_rd                      = '0;
        ctrl_rd[B_RUN]               = ctrl_q.run;
        ctrl_rd[B_CMP_EN]            = ctrl_q.cmp_en;
        ctrl_rd[B_IRQ_EN]            = ctrl_q.irq_en;
        ctrl_rd[B_AUTO]              = ctrl_q.auto_en;
        ctrl_rd[B_DIV_LSB +: DIV_W]  = div_q;
        stat_rd                      = '0;
        stat_rd[B_FLAG]              = flag;
    end

    // Read multiplexer: live values, no snapshot.
    always_comb begin
        case (idx)
            IDX_W'(W_CNT_LO): bus_rdata = cnt[0 +: BUS_W];
            IDX_W'(W_CNT_HI): bus_rdata = cnt[BUS_W +: BUS_W];
            IDX_W'(W_CTRL):   bus_rdata = ctrl_rd;
            IDX_W'(W_STAT):   bus_rdata = stat_rd;
            IDX_W'(W_CMP_LO): bus_rdata = cmp[0 +: BUS_W];
            IDX_W'(W_CMP_HI): bus_rdata = cmp[BUS_W +: BUS_W];
            IDX_W'(W_STEP):   bus_rdata = step_q;
            default:          bus_rdata = '0;
        endcase
    end

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ctrl_q.irq_en); // R8
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !(|cnt_wr)) |=> $stable(cnt)); // R2
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(ctrl_q.cmp_en && (cnt >= cmp))) |=> !flag); // R5
endmodule

// File: tb/cmp_timer_tb.sv
// Bench for cmp_timer: directed corner cases followed by seeded random
// register traffic, with every read and the interrupt line compared against
// a cycle model written from the requirements.
module cmp_timer_tb;
    logic        clk;
    logic        rst_n;
    logic [4:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks;
    int errors;
    bit done;

    cmp_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Model state
    logic [63:0] m_cnt, m_cmp;
    logic [7:0]  m_phase, m_div;
    logic [31:0] m_step;
    logic        m_run, m_ce, m_ie, m_ae, m_flag, m_held;

    always @(posedge clk) begin
        logic tick, ge, ev;
        logic [63:0] ncnt, ncmp;
        if (!rst_n) begin
            m_cnt = '0; m_cmp = '0; m_phase = '0; m_div = '0; m_step = '0;
            m_run = 0; m_ce = 0; m_ie = 0; m_ae = 0; m_flag = 0; m_held = 0;
        end else begin
            tick = m_run && (m_phase >= m_div);
            ge   = m_ce && (m_cnt >= m_cmp);
            ev   = ge && !m_held;
            ncnt = tick ? m_cnt + 64'd1 : m_cnt;
            ncmp = (ev && m_ae) ? m_cmp + {32'd0, m_step} : m_cmp;
            m_held  = ge && !(ev && m_ae);
            m_phase = (!m_run || tick) ? 8'd0 : m_phase + 8'd1;
            if (ev) m_flag = 1'b1;
            else if (bus_wr && bus_addr[4:2] == 3'd3 && bus_wdata[0]) m_flag = 1'b0;
            if (bus_wr) begin
                case (bus_addr[4:2])
                    3'd0: ncnt[31:0]  = bus_wdata;
                    3'd1: ncnt[63:32] = bus_wdata;
                    3'd2: begin
                        m_run = bus_wdata[0]; m_ce = bus_wdata[1];
                        m_ie = bus_wdata[2]; m_ae = bus_wdata[3];
                        m_div = bus_wdata[15:8];
                    end
                    3'd4: ncmp[31:0]  = bus_wdata;
                    3'd5: ncmp[63:32] = bus_wdata;
                    3'd6: m_step = bus_wdata;
                    default: ;
                endcase
            end
            m_cnt = ncnt;
            m_cmp = ncmp;
        end
    end

    function automatic logic [31:0] model_read(input logic [4:0] a);
        case (a[4:2])
            3'd0: return m_cnt[31:0];
            3'd1: return m_cnt[63:32];
            3'd2: return {16'd0, m_div, 4'd0, m_ae, m_ie, m_ce, m_run};
            3'd3: return {31'd0, m_flag};
            3'd4: return m_cmp[31:0];
            3'd5: return m_cmp[63:32];
            3'd6: return m_step;
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
        end
    endtask

    // Called at a negedge: writes one word, returns at the next negedge.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] lo;
        void'($urandom(32'd20240611));
        checks = 0; errors = 0; done = 0;
        rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(5'(a * 4), v);
            check("R1 reset read", {32'd0, v}, 64'd0);
        end
        check("R1 irq after reset", {63'd0, irq_o}, 64'd0);
        idle(3);
        rd(5'h00, v);
        check("R1 counter stopped", {32'd0, v}, 64'd0);

        // R10: control readback mask and unused word
        wr(5'h08, 32'hFFFF_FFFF);
        rd(5'h08, v);
        check("R10 control mask", {32'd0, v}, 64'h0000_FF0F);
        rd(5'h1C, v);
        check("R10 unused word", {32'd0, v}, 64'd0);
        wr(5'h08, 32'h0);
        wr(5'h0C, 32'h1);

        // R3: write halves, tearing across a carry
        wr(5'h00, 32'hFFFF_FFFF);
        wr(5'h04, 32'h0);
        rd(5'h00, v);
        check("R3 write low", {32'd0, v}, 64'hFFFF_FFFF);
        wr(5'h08, 32'h0000_0001);
        rd(5'h00, lo);
        @(negedge clk);
        rd(5'h04, v);
        check("R3 torn pair", {v, lo}, 64'h0000_0001_FFFF_FFFF);

        // R2: divider 3 pacing
        wr(5'h08, 32'h0);
        wr(5'h00, 32'h0);
        wr(5'h04, 32'h0);
        wr(5'h08, 32'h0000_0301);
        idle(20);
        rd(5'h00, v);
        check("R2 divided count", {32'd0, v}, {32'd0, model_read(5'h00)});
        check("R2 divided count value", {32'd0, v}, 64'd5);
        wr(5'h08, 32'h0);
        rd(5'h00, lo);
        idle(5);
        rd(5'h00, v);
        check("R2 hold when stopped", {32'd0, v}, {32'd0, lo});

        // R4: greater-or-equal raises the flag
        wr(5'h00, 32'd100);
        wr(5'h10, 32'd50);
        wr(5'h14, 32'd0);
        wr(5'h0C, 32'h1);
        wr(5'h08, 32'h0000_0002);
        @(negedge clk);
        rd(5'h0C, v);
        check("R4 flag on counter past target", {32'd0, v}, 64'd1);
        check("R8 irq gated off", {63'd0, irq_o}, 64'd0);
        wr(5'h08, 32'h0000_0006);
        check("R8 irq when enabled", {63'd0, irq_o}, 64'd1);

        // R5/R6: clear while condition holds stays clear
        wr(5'h0C, 32'h1);
        idle(4);
        rd(5'h0C, v);
        check("R6 no retrigger while held", {32'd0, v}, 64'd0);
        check("R5 irq follows clear", {63'd0, irq_o}, 64'd0);
        wr(5'h10, 32'd200);
        wr(5'h10, 32'd50);
        @(negedge clk);
        rd(5'h0C, v);
        check("R6 rearm after drop", {32'd0, v}, 64'd1);
        wr(5'h0C, 32'h0);
        rd(5'h0C, v);
        check("R5 write zero no effect", {32'd0, v}, 64'd1);

        // R9: compare off, rewriting target raises nothing
        wr(5'h08, 32'h0000_0004);
        wr(5'h0C, 32'h1);
        wr(5'h10, 32'd10);
        wr(5'h14, 32'd0);
        idle(3);
        rd(5'h0C, v);
        check("R9 no event when off", {32'd0, v}, 64'd0);
        check("R9 irq stays low", {63'd0, irq_o}, 64'd0);

        // R7: auto-step gives one event per step
        wr(5'h08, 32'h0);
        wr(5'h00, 32'd0);
        wr(5'h10, 32'd20);
        wr(5'h18, 32'd25);
        wr(5'h0C, 32'h1);
        wr(5'h08, 32'h0000_000B);
        idle(50);
        rd(5'h10, v);
        check("R7 target stepped twice", {32'd0, v}, 64'd70);
        rd(5'h0C, v);
        check("R7 flag from step event", {32'd0, v}, 64'd1);

        // Random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            int unsigned op;
            logic [4:0] a;
            logic [31:0] d;
            rd(5'($urandom_range(0, 7) * 4), v);
            check("R2/R3/R4/R7 random read", {32'd0, v}, {32'd0, model_read(bus_addr)});
            check("R8 random irq", {63'd0, irq_o}, {63'd0, m_flag && m_ie});
            op = $urandom_range(0, 99);
            if (op < 25) begin
                a = 5'($urandom_range(0, 7) * 4);
                case (a[4:2])
                    3'd0: d = m_cnt[31:0] + $urandom_range(0, 40);
                    3'd1: d = ($urandom_range(0, 9) == 0) ? 32'd1 : m_cnt[63:32];
                    3'd2: d = {$urandom_range(0, 65535), 16'd0} |
                              {16'd0, 8'($urandom_range(0, 3)), 4'($urandom), 4'($urandom)};
                    3'd3: d = $urandom;
                    3'd4: d = m_cnt[31:0] + $urandom_range(0, 60);
                    3'd5: d = m_cnt[63:32];
                    3'd6: d = $urandom_range(0, 30);
                    default: d = $urandom;
                endcase
                bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
            end
            @(negedge clk);
            bus_wr = 1'b0;
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule